// File: doc/BRIEF.md
# Memory-Mapped Peripheral Register and Interrupt Front-End

This block is the register face of a small memory-mapped peripheral. A host issues single-beat 32-bit reads and writes over a simple valid/write/address/data port into a 1 MiB window, which a system maps as a memory-space base region. The block keeps a constant identification word, three plain read/write words (a scratch word used to probe that the device is alive, an operand/result word for a computation engine that lives elsewhere, and a status word), and a 32-bit pending-interrupt word. Read data is returned on the cycle after the read is accepted, flagged by a response-valid strobe.

Interrupt bits are never cleared by writing to the pending word. Instead, two write-only offsets act as set and clear ports: data written to the set offset is ORed into the pending word, and data written to the clear offset removes the bits that are one in the data. A one-cycle pulse from an on-chip DMA engine sets a fixed DMA bit. The level interrupt output stays high while any pending bit is one.

The bus side is sequenced by a two-state machine. `ST_IDLE` is the resting state with no response on the bus. The transition IDLE-to-RESP fires when a read is accepted; `ST_RESP` drives the captured read word with the valid strobe for exactly one cycle. The transition RESP-to-RESP fires when another read is accepted during the response cycle (back-to-back reads), and RESP-to-IDLE fires on any cycle without a read. IDLE-to-IDLE holds otherwise. Writes complete in the cycle they are presented and never enter `ST_RESP`.

Top module: `mmdev_regfront`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is 0, `rsp_data` is 0, `irq_level` is 0, and every stored word (scratch, compute, status, pending) reads back as 0.
- R2: A read of offset 0x00 returns the parameter `IDENT_WORD` (default 0xC0DE0100); a write to 0x00 has no effect.
- R3: Offset 0x04 is a read/write scratch word: a read returns the last value written there.
- R4: Offset 0x08 is a read/write compute word: a read returns the last value written there.
- R5: Offset 0x20 is a read/write status word: a read returns the last value written there.
- R6: Offset 0x24 returns the 32-bit pending-interrupt word and is read-only: a write to it leaves the pending word unchanged.
- R7: A write to offset 0x60 ORs the write data into the pending word; bits already set stay set.
- R8: A write to offset 0x64 clears each pending bit whose write-data bit is 1 and leaves the others unchanged.
- R9: `irq_level` is 1 exactly when the pending word is non-zero, and follows it from the cycle after the write or pulse that changed it.
- R10: Reads of any offset not listed in R2 to R6 (including 0x60, 0x64 and any address whose low two bits are not zero) return 0xFFFFFFFF; writes there change no stored word.
- R11: A one-cycle `dma_done` pulse sets pending bit 8 (`DMA_BIT`); if a clear write to 0x64 naming bit 8 lands in the same cycle, bit 8 still ends up set.
- R12: `rsp_valid` is 1 on exactly the cycle after an accepted read (including back-to-back reads) and 0 after writes and idle cycles; `rsp_data` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after the read) |
| rsp_data | output | 32 | Read data |
| dma_done | input | 1 | One-cycle DMA completion pulse |
| irq_level | output | 1 | Level interrupt, high while any bit pending |

## Verification
The register words are written with distinct patterns (alternating bits, a walking pattern and all ones) so that a swapped decode between two slots, or a slot that ignores its write, shows up as a wrong read value. The pending word is driven through set, partial clear and full clear sequences, which tells an OR merge apart from an overwrite and a masked clear apart from a full wipe, while `irq_level` is watched across the non-zero to zero edge. Unmapped, write-only and misaligned offsets are read and written to separate the all-ones default from any aliasing onto a real slot, and a DMA pulse colliding with a clear of the same bit shows which of the two takes priority. Back-to-back reads and a read after a write distinguish the RESP-to-RESP path from the RESP-to-IDLE path.

// File: rtl/mmdev_pkg.sv
package mmdev_pkg;

    localparam int unsigned WORD_W = 32;

    // Byte offsets inside the window
    localparam int unsigned OFS_IDENT   = 32'h00;
    localparam int unsigned OFS_SCRATCH = 32'h04;
    localparam int unsigned OFS_CALC    = 32'h08;
    localparam int unsigned OFS_STAT    = 32'h20;
    localparam int unsigned OFS_PEND    = 32'h24;
    localparam int unsigned OFS_SET     = 32'h60;
    localparam int unsigned OFS_CLR     = 32'h64;

    // Slot numbers in the read/write bank
    localparam int unsigned RW_COUNT    = 3;
    localparam int unsigned SLOT_SCRATCH = 0;
    localparam int unsigned SLOT_CALC    = 1;
    localparam int unsigned SLOT_STAT    = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_SCRATCH,
        SEL_CALC,
        SEL_STAT,
        SEL_PEND,
        SEL_SET,
        SEL_CLR
    } sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    // Map a decoded target onto a bank slot; RW_COUNT means "not a bank slot"
    function automatic int unsigned slot_of(sel_e s);
        case (s)
            SEL_SCRATCH: slot_of = SLOT_SCRATCH;
            SEL_CALC:    slot_of = SLOT_CALC;
            SEL_STAT:    slot_of = SLOT_STAT;
            default:     slot_of = RW_COUNT;
        endcase
    endfunction

endpackage

// File: rtl/mmdev_decode.sv
module mmdev_decode
    import mmdev_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);

    always_comb begin
        case (addr)
            ADDR_W'(OFS_IDENT):   sel = SEL_IDENT;
            ADDR_W'(OFS_SCRATCH): sel = SEL_SCRATCH;
            ADDR_W'(OFS_CALC):    sel = SEL_CALC;
            ADDR_W'(OFS_STAT):    sel = SEL_STAT;
            ADDR_W'(OFS_PEND):    sel = SEL_PEND;
            ADDR_W'(OFS_SET):     sel = SEL_SET;
            ADDR_W'(OFS_CLR):     sel = SEL_CLR;
            default:              sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/mmdev_rwbank.sv
module mmdev_rwbank #(
    parameter int unsigned COUNT = 3,
    parameter int unsigned WIDTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [COUNT-1:0]            wr_en,
    input  logic [WIDTH-1:0]            wdata,
    output logic [COUNT-1:0][WIDTH-1:0] q
);

    for (genvar i = 0; i < COUNT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (wr_en[i]) begin
                q[i] <= wdata;
            end
        end

        // R3, R4, R5: a written slot holds the write data next cycle
        a_r3_slot_store: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en[i]) |-> q[i] == $past(wdata));

        // R10: a slot not written keeps its value
        a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(wr_en[i]) |-> $stable(q[i]));
    end

endmodule

// File: rtl/mmdev_irq.sv
module mmdev_irq #(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned DMA_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic             dma_done,
    output logic [WIDTH-1:0] pending,
    output logic             irq_level
);

    localparam logic [WIDTH-1:0] DMA_MASK = WIDTH'(1) << DMA_BIT;

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] pend_d;

    always_comb begin
        set_mask = (set_en ? wdata : '0) | (dma_done ? DMA_MASK : '0);
        clr_mask = clr_en ? wdata : '0;
        // Clear first, then set: a DMA event is never lost to a racing clear
        pend_d   = (pending & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= pend_d;
        end
    end

    assign irq_level = |pending;

    // R7: every bit written to the set port is pending next cycle
    a_r7_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_en) |-> ((pending & $past(wdata)) == $past(wdata)));

    // R7: set never drops a bit (no clear in the same cycle)
    a_r7_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_en) && !$past(clr_en)) |-> ((pending & $past(pending)) == $past(pending)));

    // R8: bits named by a clear are gone unless the DMA pulse re-sets its bit
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_en) && !$past(dma_done)) |-> ((pending & $past(wdata)) == '0));

    // R11: a DMA pulse leaves the DMA bit pending
    a_r11_dma_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dma_done) |-> pending[DMA_BIT]);

    // R6: with no source active the pending word does not move
    a_r6_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(set_en) && !$past(clr_en) && !$past(dma_done)) |-> $stable(pending));

endmodule

// File: rtl/mmdev_regfront.sv
module mmdev_regfront
    import mmdev_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 20,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       DMA_BIT    = 8,
    parameter logic [DATA_W-1:0] IDENT_WORD = 32'hC0DE_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              dma_done,
    output logic              irq_level
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    sel_e                              sel;
    bus_state_e                        state_q;
    bus_state_e                        state_d;
    logic                              rd_acc;
    logic                              wr_acc;
    logic [RW_COUNT-1:0]               rw_wr;
    logic [RW_COUNT-1:0][DATA_W-1:0]   rw_q;
    logic [DATA_W-1:0]                 pending;
    logic [DATA_W-1:0]                 rd_word;
    logic [DATA_W-1:0]                 rdata_q;

    mmdev_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    assign rd_acc = req_valid && !req_write;
    assign wr_acc = req_valid &&  req_write;

    for (genvar i = 0; i < RW_COUNT; i++) begin : g_wr
        assign rw_wr[i] = wr_acc && (slot_of(sel) == i);
    end

    mmdev_rwbank #(.COUNT(RW_COUNT), .WIDTH(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (rw_wr),
        .wdata (req_wdata),
        .q     (rw_q)
    );

    mmdev_irq #(.WIDTH(DATA_W), .DMA_BIT(DMA_BIT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (wr_acc && (sel == SEL_SET)),
        .clr_en    (wr_acc && (sel == SEL_CLR)),
        .wdata     (req_wdata),
        .dma_done  (dma_done),
        .pending   (pending),
        .irq_level (irq_level)
    );

    // Read multiplexer
    always_comb begin
        unique case (sel)
            SEL_IDENT:   rd_word = IDENT_WORD;
            SEL_SCRATCH: rd_word = rw_q[SLOT_SCRATCH];
            SEL_CALC:    rd_word = rw_q[SLOT_CALC];
            SEL_STAT:    rd_word = rw_q[SLOT_STAT];
            SEL_PEND:    rd_word = pending;
            default:     rd_word = ALL_ONES;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            rdata_q <= rd_word;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_data  = rdata_q;
            end
            default: ;
        endcase
    end

    // R12: a read is answered on the next cycle
    a_r12_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_acc) |-> rsp_valid);

    // R12: no response without a read the cycle before
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_acc) |-> !rsp_valid);

    // R2: identification reads return the constant
    a_r2_ident: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_acc) && $past(sel) == SEL_IDENT) |-> rsp_data == IDENT_WORD);

    // R10: unmapped and write-only offsets read as all ones
    a_r10_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_acc) && ($past(sel) == SEL_NONE || $past(sel) == SEL_SET ||
                           $past(sel) == SEL_CLR)) |-> rsp_data == ALL_ONES);

    // R9: interrupt level tracks the pending word
    a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pending) == 0) |-> !irq_level);

    // R1: idle outputs right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> (!rsp_valid && rsp_data == '0));

endmodule

// File: tb/mmdev_regfront_tb.sv
module mmdev_regfront_tb;

    localparam logic [31:0] IDENT = 32'hC0DE_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        dma_done = 1'b0;
    logic        irq_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmdev_regfront u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .dma_done  (dma_done),
        .irq_level (irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rsp_data; v = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 rsp_data", rsp_data, 32'd0);
        check("R1 irq_level", 32'(irq_level), 32'd0);
        rd(20'h04, d, v); check("R1 scratch", d, 32'd0);
        rd(20'h08, d, v); check("R1 compute", d, 32'd0);
        rd(20'h20, d, v); check("R1 status", d, 32'd0);
        rd(20'h24, d, v); check("R1 pending", d, 32'd0);
    endtask

    task automatic t_ident();
        logic [31:0] d; logic v;
        rd(20'h00, d, v); check("R2 ident", d, IDENT);
        wr(20'h00, 32'h1234_5678);
        rd(20'h00, d, v); check("R2 ident after write", d, IDENT);
    endtask

    task automatic t_rw();
        logic [31:0] d; logic v;
        wr(20'h04, 32'hA5A5_5A5A);
        wr(20'h08, 32'h0102_0408);
        wr(20'h20, 32'hFFFF_FFFF);
        rd(20'h04, d, v); check("R3 scratch", d, 32'hA5A5_5A5A);
        rd(20'h08, d, v); check("R4 compute", d, 32'h0102_0408);
        rd(20'h20, d, v); check("R5 status", d, 32'hFFFF_FFFF);
        wr(20'h04, 32'h0000_0001);
        rd(20'h04, d, v); check("R3 scratch rewrite", d, 32'h0000_0001);
        rd(20'h08, d, v); check("R4 compute untouched", d, 32'h0102_0408);
    endtask

    task automatic t_irq();
        logic [31:0] d; logic v;
        wr(20'h60, 32'h0000_0005);
        check("R9 level after set", 32'(irq_level), 32'd1);
        wr(20'h60, 32'h8000_0000);
        rd(20'h24, d, v); check("R7 set merges", d, 32'h8000_0005);
        wr(20'h24, 32'h0000_0000);
        rd(20'h24, d, v); check("R6 pending read-only", d, 32'h8000_0005);
        wr(20'h64, 32'h0000_0004);
        rd(20'h24, d, v); check("R8 partial clear", d, 32'h8000_0001);
        check("R9 level still high", 32'(irq_level), 32'd1);
        wr(20'h64, 32'hFFFF_FFFF);
        check("R9 level low after clear", 32'(irq_level), 32'd0);
        rd(20'h24, d, v); check("R8 full clear", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic v;
        rd(20'h60, d, v); check("R10 set port reads ones", d, 32'hFFFF_FFFF);
        rd(20'h64, d, v); check("R10 clear port reads ones", d, 32'hFFFF_FFFF);
        rd(20'h10, d, v); check("R10 hole reads ones", d, 32'hFFFF_FFFF);
        rd(20'h06, d, v); check("R10 misaligned reads ones", d, 32'hFFFF_FFFF);
        rd(20'hFFFFC, d, v); check("R10 top of window", d, 32'hFFFF_FFFF);
        wr(20'h10, 32'hDEAD_BEEF);
        wr(20'h05, 32'hDEAD_BEEF);
        rd(20'h04, d, v); check("R10 scratch kept", d, 32'h0000_0001);
        rd(20'h08, d, v); check("R10 compute kept", d, 32'h0102_0408);
        rd(20'h20, d, v); check("R10 status kept", d, 32'hFFFF_FFFF);
        rd(20'h24, d, v); check("R10 pending kept", d, 32'h0);
        check("R10 level kept", 32'(irq_level), 32'd0);
    endtask

    task automatic t_dma();
        logic [31:0] d; logic v;
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        check("R11 level after pulse", 32'(irq_level), 32'd1);
        rd(20'h24, d, v); check("R11 dma bit", d, 32'h0000_0100);
        wr(20'h60, 32'h0000_0002);
        // Clear bits 8 and 1 while the pulse arrives in the same cycle
        @(negedge clk);
        dma_done = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        req_addr = 20'h64; req_wdata = 32'h0000_0102;
        @(negedge clk);
        dma_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        rd(20'h24, d, v); check("R11 pulse beats clear", d, 32'h0000_0100);
        wr(20'h64, 32'h0000_0100);
        rd(20'h24, d, v); check("R11 cleared afterwards", d, 32'h0);
    endtask

    task automatic t_handshake();
        logic [31:0] d; logic v;
        rd(20'h00, d, v); check("R12 valid on read", 32'(v), 32'd1);
        // back-to-back reads
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h04;
        @(negedge clk);
        check("R12 first of pair valid", 32'(rsp_valid), 32'd1);
        check("R12 first of pair data", rsp_data, 32'h0000_0001);
        req_addr = 20'h00;
        @(negedge clk);
        check("R12 second of pair valid", 32'(rsp_valid), 32'd1);
        check("R12 second of pair data", rsp_data, IDENT);
        req_valid = 1'b0;
        @(negedge clk);
        check("R12 idle no valid", 32'(rsp_valid), 32'd0);
        check("R12 idle data zero", rsp_data, 32'd0);
        wr(20'h04, 32'h0000_0002);
        check("R12 no valid after write", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_rw();
        t_irq();
        t_unmapped();
        t_dma();
        t_handshake();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule